// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel whose work is described entirely by descriptors that sit in memory. Software writes the address of the first descriptor and sets the run bit. The channel then reads the descriptor, copies its fields into working registers and moves data one 32-bit word at a time over a simple word-wide memory master port. The same port is used for descriptor fetches, data reads and data writes. Each descriptor names the next one. A zero link ends the chain, and the channel then sits idle with a zero descriptor address.

A descriptor is eight 32-bit words (256 bits) and lies on a 32-byte boundary. The words are ordered as follows: control flags, source address, destination address, byte count, stride, link, and then two unused words. Per word, the flags can request these behaviours:
- source and destination address stepping;
- pacing by a peripheral request line;
- a zero-fill source that performs no reads;
- a discarded destination that performs no writes;
- waiting for write acknowledgements;
- an interrupt when the descriptor ends.

Software controls the channel through a small register window. It can pause the channel, skip the current descriptor, reset the channel and clear the status flags. A build-time option selects a reduced variant. That variant caps the byte count of each descriptor and reports the cap in a debug register.

Top module: `cbdma_channel`

## Requirements
- R1: After reset, the status register (word index 0) reads 0x10 (only the stopped bit 4 set, with the request input low). The descriptor address, flags, source, destination and byte count registers read 0, and `irq` is low.
- R2: When run (status bit 0) is 1 and the descriptor address (index 1) is nonzero, the channel reads six words at address+0, +4, ... +20. It loads them in order into flags (index 2), source (3), destination (4), byte count (5), stride (6) and link (7).
- R3: Each word moved reads the source address and writes the word to the destination address. Source steps by 4 when flag bit 8 is set, destination steps by 4 when flag bit 4 is set, and the byte count drops by 4 per word.
- R4: When the byte count reaches 0, status bit 1 (end) is set. If flag bit 0 is set, status bit 2 (interrupt) and `irq` are set too. The link is then copied into the descriptor address. A zero link leaves the channel idle with address 0 while the run bit stays 1.
- R5: Writing 1 to status bit 1 or bit 2 clears that bit. Writing bit 2 together with bit 0 drops `irq` and leaves run at 1.
- R6: With flag bit 11, the channel performs no source read and writes zero. With flag bit 7, the channel performs no write, but the addresses and byte count still advance.
- R7: With flag bit 10 or bit 6, each word waits for `dreq` high. While it waits, status bit 5 (held) is 1. Status bit 3 always mirrors `dreq`.
- R8: Writing 0 to run stops the channel after the word in progress, and status bit 4 is 1. Writing 1 to run resumes where the channel stopped.
- R9: Status bit 6 is 1 while writes are unacknowledged. At most `OUTST_MAX` writes are outstanding. With flag bit 3, each word waits until all of its writes are acknowledged.
- R10: Writing 1 to status bit 30 ends the current descriptor at a word boundary, without setting end or interrupt, and the channel continues at the link.
- R11: Writing 1 to status bit 31 clears run, the descriptor address, the working registers and the end and interrupt bits, and stops all data movement.
- R12: Writes to the descriptor address drop the low 5 bits.
- R13: In the reduced variant (`LITE`=1), debug register (index 8) bit 28 reads 1, and a loaded byte count above `LITE_MAX_LEN` becomes `LITE_MAX_LEN`. In the full variant, bit 28 reads 0.
- R14: The low 2 bits of a loaded byte count are dropped. A descriptor with a byte count of 0 ends at once, with no data read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_idx | input | 4 | Register word index (byte offset / 4) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` (combinational) |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| mem_wresp | input | 1 | One write acknowledged |
| dreq | input | 1 | Peripheral data request |
| irq | output | 1 | Interrupt, equal to status bit 2 |

## Verification
The copy path is run with these flag patterns:
- Both addresses stepping, which shows whether each word lands in its own place.
- A fixed source, which shows that the same word is reread.
- A zero-fill source and a discarded destination, which separate the read side from the write side.
- A two-descriptor chain, which shows that link following and the interrupt enable act per descriptor.

Flow control is checked with the request line held low, with write acknowledgements withheld (which fills the outstanding-write limit), and with and without the wait-for-acknowledge flag. Each case stops the byte count at a different, predictable value. Abort, pause, soft reset and odd or zero byte counts are each checked against memory contents and register reads.

// File: rtl/cbdma_pkg.sv
package cbdma_pkg;

   // engine states
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_XFER,
      ST_RD,
      ST_WR,
      ST_WRESP,
      ST_DONE
   } eng_state_e;

   // descriptor flag bit positions (software encodes them)
   localparam int TI_IRQ_EN   = 0;
   localparam int TI_WAIT_ACK = 3;
   localparam int TI_DST_INC  = 4;
   localparam int TI_DST_PACE = 6;
   localparam int TI_DST_DROP = 7;
   localparam int TI_SRC_INC  = 8;
   localparam int TI_SRC_PACE = 10;
   localparam int TI_SRC_ZERO = 11;

   // status register bit positions
   localparam int CS_RUN     = 0;
   localparam int CS_DONE    = 1;
   localparam int CS_IRQ     = 2;
   localparam int CS_REQ     = 3;
   localparam int CS_STOPPED = 4;
   localparam int CS_HELD    = 5;
   localparam int CS_DRAIN   = 6;
   localparam int CS_SKIP    = 30;
   localparam int CS_CLEAR   = 31;

   localparam int DBG_REDUCED = 28;

   // register word indices
   localparam logic [3:0] RI_CS     = 4'd0;
   localparam logic [3:0] RI_CBA    = 4'd1;
   localparam logic [3:0] RI_TI     = 4'd2;
   localparam logic [3:0] RI_SRC    = 4'd3;
   localparam logic [3:0] RI_DST    = 4'd4;
   localparam logic [3:0] RI_LEN    = 4'd5;
   localparam logic [3:0] RI_STRIDE = 4'd6;
   localparam logic [3:0] RI_NEXT   = 4'd7;
   localparam logic [3:0] RI_DEBUG  = 4'd8;

   // decoded status-register write
   typedef struct packed {
      logic run;
      logic clr_done;
      logic clr_irq;
      logic skip;
      logic clear;
   } cs_cmd_t;

endpackage

// File: rtl/cbdma_wrtrack.sv
module cbdma_wrtrack #(
   parameter int unsigned OUTST_MAX = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   input  logic resp,
   output logic full,
   output logic empty
);
   localparam int CW = $clog2(OUTST_MAX + 1);
   localparam logic [CW-1:0] CNT_MAX = CW'(OUTST_MAX);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         case ({issue, resp})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign full  = (cnt_q == CNT_MAX);
   assign empty = (cnt_q == '0);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX) |-> !issue); // R9
   AST_RESP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      resp |-> (cnt_q != '0)); // R9

endmodule

// File: rtl/cbdma_engine.sv
module cbdma_engine
   import cbdma_pkg::*;
#(
   parameter bit          LITE         = 1'b0,
   parameter int unsigned LITE_MAX_LEN = 65532
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs_we,
   input  cs_cmd_t     cs_cmd,
   input  logic        cba_we,
   input  logic [31:0] cba_wdata,
   input  logic        dreq,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata,
   input  logic        wr_full,
   input  logic        wr_empty,
   output logic        wr_issue,
   output logic [31:0] cba_q,
   output logic [31:0] ti_q,
   output logic [31:0] src_q,
   output logic [31:0] dst_q,
   output logic [31:0] len_q,
   output logic [31:0] stride_q,
   output logic [31:0] next_q,
   output logic        run_q,
   output logic        done_q,
   output logic        irq_q,
   output logic        held
);
   localparam logic [31:0] STEP       = 32'd4;
   localparam logic [31:0] ALIGN_MASK = ~32'h1F;
   localparam logic [31:0] WORD_MASK  = ~32'h3;
   localparam logic [2:0]  LAST_FIDX  = 3'd5;

   eng_state_e  st_q;
   logic [2:0]  fidx_q;
   logic [31:0] data_q;
   logic        skip_q;
   logic        paced;
   logic        drop;
   logic        step_done;
   logic [31:0] len_fit;

   generate
      if (LITE) begin : g_reduced_len
         always_comb begin
            if (mem_rdata > 32'(LITE_MAX_LEN)) len_fit = 32'(LITE_MAX_LEN) & WORD_MASK;
            else                               len_fit = mem_rdata & WORD_MASK;
         end
      end else begin : g_full_len
         always_comb len_fit = mem_rdata & WORD_MASK;
      end
   endgenerate

   always_comb begin
      paced     = ti_q[TI_SRC_PACE] | ti_q[TI_DST_PACE];
      drop      = ti_q[TI_DST_DROP];
      held      = (st_q == ST_XFER) && run_q && !skip_q && (len_q != '0) && paced && !dreq;
      mem_req   = (st_q == ST_FETCH) || (st_q == ST_RD) ||
                  ((st_q == ST_WR) && !drop && !wr_full);
      mem_we    = (st_q == ST_WR);
      mem_wdata = data_q;
      case (st_q)
         ST_FETCH: mem_addr = cba_q + {27'd0, fidx_q, 2'b00};
         ST_RD:    mem_addr = src_q;
         ST_WR:    mem_addr = dst_q;
         default:  mem_addr = '0;
      endcase
      wr_issue  = (st_q == ST_WR) && mem_req && mem_ack;
      step_done = (st_q == ST_WR) && (drop || (mem_req && mem_ack));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE; fidx_q <= '0; data_q <= '0; skip_q <= 1'b0;
         cba_q <= '0; ti_q <= '0; src_q <= '0; dst_q <= '0;
         len_q <= '0; stride_q <= '0; next_q <= '0;
         run_q <= 1'b0; done_q <= 1'b0; irq_q <= 1'b0;
      end else if (cs_we && cs_cmd.clear) begin
         st_q <= ST_IDLE; fidx_q <= '0; data_q <= '0; skip_q <= 1'b0;
         cba_q <= '0; ti_q <= '0; src_q <= '0; dst_q <= '0;
         len_q <= '0; stride_q <= '0; next_q <= '0;
         run_q <= 1'b0; done_q <= 1'b0; irq_q <= 1'b0;
      end else begin
         if (cs_we) begin
            run_q <= cs_cmd.run;
            if (cs_cmd.clr_done) done_q <= 1'b0;
            if (cs_cmd.clr_irq)  irq_q  <= 1'b0;
            if (cs_cmd.skip)     skip_q <= 1'b1;
         end
         if (cba_we) cba_q <= cba_wdata & ALIGN_MASK;
         case (st_q)
            ST_IDLE: begin
               skip_q <= 1'b0;
               if (run_q && (cba_q != '0)) begin
                  fidx_q <= '0;
                  st_q   <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  case (fidx_q)
                     3'd0:    ti_q     <= mem_rdata;
                     3'd1:    src_q    <= mem_rdata;
                     3'd2:    dst_q    <= mem_rdata;
                     3'd3:    len_q    <= len_fit;
                     3'd4:    stride_q <= mem_rdata;
                     default: next_q   <= mem_rdata;
                  endcase
                  if (fidx_q == LAST_FIDX) st_q <= ST_XFER;
                  else                     fidx_q <= fidx_q + 1'b1;
               end
            end
            ST_XFER: begin
               if (skip_q) begin
                  skip_q <= 1'b0;
                  cba_q  <= next_q;
                  st_q   <= ST_IDLE;
               end else if (len_q == '0) begin
                  st_q <= ST_DONE;
               end else if (run_q && !(paced && !dreq)) begin
                  if (ti_q[TI_SRC_ZERO]) begin
                     data_q <= '0;
                     st_q   <= ST_WR;
                  end else begin
                     st_q <= ST_RD;
                  end
               end
            end
            ST_RD: begin
               if (mem_ack) begin
                  data_q <= mem_rdata;
                  st_q   <= ST_WR;
               end
            end
            ST_WR: begin
               if (step_done) begin
                  if (ti_q[TI_SRC_INC]) src_q <= src_q + STEP;
                  if (ti_q[TI_DST_INC]) dst_q <= dst_q + STEP;
                  len_q <= len_q - STEP;
                  st_q  <= (ti_q[TI_WAIT_ACK] && !drop) ? ST_WRESP : ST_XFER;
               end
            end
            ST_WRESP: begin
               if (wr_empty) st_q <= ST_XFER;
            end
            ST_DONE: begin
               done_q <= 1'b1;
               if (ti_q[TI_IRQ_EN]) irq_q <= 1'b1;
               cba_q <= next_q;
               st_q  <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> !mem_req); // R2
   AST_MOVE_HAS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RD || st_q == ST_WR) |-> (len_q != '0)); // R14
   AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> !mem_req); // R7
   AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_XFER && !run_q) |=> (st_q != ST_RD && st_q != ST_WR)); // R8
   AST_CHAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DONE && next_q == '0 && !cba_we && !(cs_we && cs_cmd.clear))
      |=> (cba_q == '0)); // R4
   AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_done && !(cs_we && cs_cmd.clear)) |=> (len_q == $past(len_q) - STEP)); // R3

endmodule

// File: rtl/cbdma_regif.sv
module cbdma_regif
   import cbdma_pkg::*;
#(
   parameter bit LITE = 1'b0
) (
   input  logic [3:0]  reg_idx,
   input  logic        reg_we,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        cs_we,
   output cs_cmd_t     cs_cmd,
   output logic        cba_we,
   input  logic [31:0] cba_q,
   input  logic [31:0] ti_q,
   input  logic [31:0] src_q,
   input  logic [31:0] dst_q,
   input  logic [31:0] len_q,
   input  logic [31:0] stride_q,
   input  logic [31:0] next_q,
   input  logic        run_q,
   input  logic        done_q,
   input  logic        irq_q,
   input  logic        held,
   input  logic        drain,
   input  logic        dreq
);
   logic [31:0] cs_view;
   logic [31:0] dbg_view;

   always_comb begin
      cs_we           = reg_we && (reg_idx == RI_CS);
      cba_we          = reg_we && (reg_idx == RI_CBA);
      cs_cmd.run      = reg_wdata[CS_RUN];
      cs_cmd.clr_done = reg_wdata[CS_DONE];
      cs_cmd.clr_irq  = reg_wdata[CS_IRQ];
      cs_cmd.skip     = reg_wdata[CS_SKIP];
      cs_cmd.clear    = reg_wdata[CS_CLEAR];

      cs_view             = '0;
      cs_view[CS_RUN]     = run_q;
      cs_view[CS_DONE]    = done_q;
      cs_view[CS_IRQ]     = irq_q;
      cs_view[CS_REQ]     = dreq;
      cs_view[CS_STOPPED] = !run_q;
      cs_view[CS_HELD]    = held;
      cs_view[CS_DRAIN]   = drain;

      dbg_view              = '0;
      dbg_view[DBG_REDUCED] = LITE;

      case (reg_idx)
         RI_CS:     reg_rdata = cs_view;
         RI_CBA:    reg_rdata = cba_q;
         RI_TI:     reg_rdata = ti_q;
         RI_SRC:    reg_rdata = src_q;
         RI_DST:    reg_rdata = dst_q;
         RI_LEN:    reg_rdata = len_q;
         RI_STRIDE: reg_rdata = stride_q;
         RI_NEXT:   reg_rdata = next_q;
         RI_DEBUG:  reg_rdata = dbg_view;
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/cbdma_channel.sv
module cbdma_channel
   import cbdma_pkg::*;
#(
   parameter bit          LITE         = 1'b0,
   parameter int unsigned LITE_MAX_LEN = 65532,
   parameter int unsigned OUTST_MAX    = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  reg_idx,
   input  logic        reg_we,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata,
   input  logic        mem_wresp,
   input  logic        dreq,
   output logic        irq
);
   generate
      if (OUTST_MAX < 1) begin : g_bad_outst
         $error("OUTST_MAX must be at least 1");
      end
      if ((LITE_MAX_LEN % 4) != 0 || LITE_MAX_LEN == 0) begin : g_bad_cap
         $error("LITE_MAX_LEN must be a nonzero multiple of 4");
      end
   endgenerate

   cs_cmd_t     cs_cmd;
   logic        cs_we, cba_we;
   logic        wr_full, wr_empty, wr_issue;
   logic [31:0] cba_q, ti_q, src_q, dst_q, len_q, stride_q, next_q;
   logic        run_q, done_q, irq_q, held;

   cbdma_regif #(.LITE(LITE)) u_regif (
      .reg_idx(reg_idx), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cs_we(cs_we), .cs_cmd(cs_cmd), .cba_we(cba_we),
      .cba_q(cba_q), .ti_q(ti_q), .src_q(src_q), .dst_q(dst_q), .len_q(len_q),
      .stride_q(stride_q), .next_q(next_q), .run_q(run_q), .done_q(done_q),
      .irq_q(irq_q), .held(held), .drain(!wr_empty), .dreq(dreq)
   );

   cbdma_engine #(.LITE(LITE), .LITE_MAX_LEN(LITE_MAX_LEN)) u_engine (
      .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .cs_cmd(cs_cmd),
      .cba_we(cba_we), .cba_wdata(reg_wdata), .dreq(dreq),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .wr_full(wr_full), .wr_empty(wr_empty), .wr_issue(wr_issue),
      .cba_q(cba_q), .ti_q(ti_q), .src_q(src_q), .dst_q(dst_q), .len_q(len_q),
      .stride_q(stride_q), .next_q(next_q), .run_q(run_q), .done_q(done_q),
      .irq_q(irq_q), .held(held)
   );

   cbdma_wrtrack #(.OUTST_MAX(OUTST_MAX)) u_wrtrack (
      .clk(clk), .rst_n(rst_n), .issue(wr_issue), .resp(mem_wresp),
      .full(wr_full), .empty(wr_empty)
   );

   assign irq = irq_q;

   AST_IRQ_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> done_q); // R4

endmodule

// File: tb/cbdma_channel_bench.sv
module cbdma_channel_bench;
   localparam int CLK_PERIOD = 10;

   localparam logic [31:0] F_IRQ  = 32'h1;
   localparam logic [31:0] F_WACK = 32'h8;
   localparam logic [31:0] F_DINC = 32'h10;
   localparam logic [31:0] F_DPAC = 32'h40;
   localparam logic [31:0] F_DDRP = 32'h80;
   localparam logic [31:0] F_SINC = 32'h100;
   localparam logic [31:0] F_SPAC = 32'h400;
   localparam logic [31:0] F_SZER = 32'h800;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // main instance
   logic [3:0]  reg_idx = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        m_req, m_we, m_ack, m_wresp;
   logic [31:0] m_addr, m_wdata, m_rdata;
   logic        dreq = 1'b0;
   logic        irq;

   // reduced instance
   logic [3:0]  l_idx = '0;
   logic        l_we = 1'b0;
   logic [31:0] l_wdata = '0;
   logic [31:0] l_rdata;
   logic        l_req, l_mwe, l_ack;
   logic [31:0] l_addr, l_mwdata, l_mrdata;
   logic        l_dreq = 1'b0;
   logic        l_irq;

   // memory model
   logic [31:0] mem [0:255];
   logic        tb_we = 1'b0;
   logic [31:0] tb_wa = '0, tb_wd = '0;
   logic        resp_hold = 1'b0;
   int          pend;

   assign m_ack    = m_req;
   assign m_rdata  = mem[m_addr[9:2]];
   assign m_wresp  = !resp_hold && (pend != 0);
   assign l_ack    = l_req;
   assign l_mrdata = mem[l_addr[9:2]];

   always @(posedge clk) begin
      if (tb_we) mem[tb_wa[9:2]] <= tb_wd;
      else if (m_req && m_we && m_ack) mem[m_addr[9:2]] <= m_wdata;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 0;
      else pend <= pend + ((m_req && m_we && m_ack) ? 1 : 0) - (m_wresp ? 1 : 0);
   end

   cbdma_channel u_cbdma_channel (
      .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(m_req), .mem_we(m_we), .mem_addr(m_addr), .mem_wdata(m_wdata),
      .mem_ack(m_ack), .mem_rdata(m_rdata), .mem_wresp(m_wresp),
      .dreq(dreq), .irq(irq)
   );

   cbdma_channel #(.LITE(1'b1)) u_cbdma_channel_lite (
      .clk(clk), .rst_n(rst_n), .reg_idx(l_idx), .reg_we(l_we),
      .reg_wdata(l_wdata), .reg_rdata(l_rdata),
      .mem_req(l_req), .mem_we(l_mwe), .mem_addr(l_addr), .mem_wdata(l_mwdata),
      .mem_ack(l_ack), .mem_rdata(l_mrdata), .mem_wresp(1'b0),
      .dreq(l_dreq), .irq(l_irq)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rw(input logic [3:0] idx, input logic [31:0] d);
      @(negedge clk);
      reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rr(input logic [3:0] idx, output logic [31:0] d);
      @(negedge clk);
      reg_idx = idx;
      #1 d = reg_rdata;
   endtask

   task automatic lw(input logic [3:0] idx, input logic [31:0] d);
      @(negedge clk);
      l_idx = idx; l_wdata = d; l_we = 1'b1;
      @(negedge clk);
      l_we = 1'b0;
   endtask

   task automatic lr(input logic [3:0] idx, output logic [31:0] d);
      @(negedge clk);
      l_idx = idx;
      #1 d = l_rdata;
   endtask

   task automatic poke(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      tb_wa = a; tb_wd = d; tb_we = 1'b1;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic put_cb(input logic [31:0] base, input logic [31:0] fl, input logic [31:0] s,
                         input logic [31:0] d, input logic [31:0] n, input logic [31:0] lnk);
      poke(base, fl); poke(base + 4, s); poke(base + 8, d);
      poke(base + 12, n); poke(base + 16, 32'h55); poke(base + 20, lnk);
   endtask

   task automatic start(input logic [31:0] base);
      rw(4'd1, base);
      rw(4'd0, 32'h1);
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 3000; i++) begin
         rr(4'd1, v);
         if (v == 32'h0) break;
      end
      repeat (6) @(negedge clk);
   endtask

   task automatic clear_cs();
      rw(4'd0, 32'h6);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rr(4'd0, v); chk("R1 status", v, 32'h10);
      rr(4'd1, v); chk("R1 cb address", v, 32'h0);
      rr(4'd2, v); chk("R1 flags", v, 32'h0);
      rr(4'd5, v); chk("R1 count", v, 32'h0);
      chk("R1 irq", {31'd0, irq}, 32'h0);
      rr(4'd8, v); chk("R13 full debug", v, 32'h0);
      lr(4'd8, v); chk("R13 reduced debug", v, 32'h1000_0000);
   endtask

   task automatic t_copy();
      logic [31:0] v;
      for (int i = 0; i < 4; i++) poke(32'h300 + 4*i, 32'h0);
      put_cb(32'h100, F_IRQ | F_SINC | F_DINC, 32'h200, 32'h300, 32'd16, 32'h0);
      start(32'h100);
      wait_idle();
      for (int i = 0; i < 4; i++) chk("R3 copy word", mem[8'hC0 + i], 32'hC0DE_0000 + i);
      rr(4'd2, v); chk("R2 flags loaded", v, F_IRQ | F_SINC | F_DINC);
      rr(4'd6, v); chk("R2 stride loaded", v, 32'h55);
      rr(4'd3, v); chk("R3 source stepped", v, 32'h210);
      rr(4'd4, v); chk("R3 dest stepped", v, 32'h310);
      rr(4'd5, v); chk("R3 count", v, 32'h0);
      rr(4'd0, v); chk("R4 status after end", v, 32'h7);
      chk("R4 irq", {31'd0, irq}, 32'h1);
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      rw(4'd0, 32'h5);
      rr(4'd0, v); chk("R5 irq clear keeps run", v, 32'h3);
      chk("R5 irq low", {31'd0, irq}, 32'h0);
      rw(4'd0, 32'h2);
      rr(4'd0, v); chk("R5 end clear", v, 32'h10);
   endtask

   task automatic t_chain();
      logic [31:0] v;
      put_cb(32'h100, F_SINC | F_DINC, 32'h200, 32'h340, 32'd8, 32'h120);
      put_cb(32'h120, F_IRQ | F_SINC | F_DINC, 32'h208, 32'h348, 32'd8, 32'h0);
      start(32'h100);
      wait_idle();
      for (int i = 0; i < 4; i++) chk("R4 chain word", mem[8'hD0 + i], 32'hC0DE_0000 + i);
      rr(4'd4, v); chk("R4 second descriptor dest", v, 32'h350);
      chk("R4 chain irq", {31'd0, irq}, 32'h1);
      clear_cs();
   endtask

   task automatic t_sources();
      logic [31:0] v;
      for (int i = 0; i < 3; i++) poke(32'h380 + 4*i, 32'hFFFF_FFFF);
      put_cb(32'h100, F_SZER | F_DINC, 32'h200, 32'h380, 32'd12, 32'h0);
      start(32'h100); wait_idle();
      for (int i = 0; i < 3; i++) chk("R6 zero fill", mem[8'hE0 + i], 32'h0);
      rr(4'd3, v); chk("R6 fixed source", v, 32'h200);
      clear_cs();
      put_cb(32'h100, F_DINC, 32'h204, 32'h390, 32'd8, 32'h0);
      start(32'h100); wait_idle();
      chk("R3 fixed source word0", mem[8'hE4], 32'hC0DE_0001);
      chk("R3 fixed source word1", mem[8'hE5], 32'hC0DE_0001);
      clear_cs();
      poke(32'h3A0, 32'hDEAD_0000); poke(32'h3A4, 32'hDEAD_0001);
      put_cb(32'h100, F_DDRP | F_SINC, 32'h200, 32'h3A0, 32'd8, 32'h0);
      start(32'h100); wait_idle();
      chk("R6 dropped write 0", mem[8'hE8], 32'hDEAD_0000);
      chk("R6 dropped write 1", mem[8'hE9], 32'hDEAD_0001);
      rr(4'd3, v); chk("R6 drop source stepped", v, 32'h208);
      rr(4'd5, v); chk("R6 drop count", v, 32'h0);
      clear_cs();
   endtask

   task automatic t_pace();
      logic [31:0] v;
      poke(32'h3C0, 32'h0); poke(32'h3C4, 32'h0);
      put_cb(32'h100, F_SPAC | F_SINC | F_DINC, 32'h200, 32'h3C0, 32'd8, 32'h0);
      dreq = 1'b0;
      start(32'h100);
      repeat (20) @(negedge clk);
      rr(4'd5, v); chk("R7 count while held", v, 32'd8);
      rr(4'd0, v); chk("R7 held status", v, 32'h21);
      chk("R7 no write while held", mem[8'hF0], 32'h0);
      @(negedge clk); dreq = 1'b1;
      rr(4'd0, v); chk("R7 request mirrored", v[3] ? 32'h1 : 32'h0, 32'h1);
      wait_idle();
      chk("R7 paced word1", mem[8'hF1], 32'hC0DE_0001);
      dreq = 1'b0;
      clear_cs();
   endtask

   task automatic t_pause();
      logic [31:0] v;
      resp_hold = 1'b1;
      for (int i = 0; i < 8; i++) poke(32'h280 + 4*i, 32'h0);
      put_cb(32'h100, F_SINC | F_DINC, 32'h200, 32'h280, 32'd32, 32'h0);
      start(32'h100);
      repeat (30) @(negedge clk);
      rr(4'd5, v); chk("R9 stop at outstanding limit", v, 32'd16);
      rw(4'd0, 32'h0);
      rr(4'd0, v); chk("R9 draining and stopped", v, 32'h50);
      resp_hold = 1'b0;
      repeat (20) @(negedge clk);
      rr(4'd5, v); chk("R8 paused after word", v, 32'd12);
      repeat (20) @(negedge clk);
      rr(4'd5, v); chk("R8 pause holds", v, 32'd12);
      rr(4'd0, v); chk("R8 paused status", v, 32'h10);
      rw(4'd0, 32'h1);
      wait_idle();
      for (int i = 0; i < 8; i++) chk("R8 resumed word", mem[8'hA0 + i], 32'hC0DE_0000 + i);
      clear_cs();
   endtask

   task automatic t_waitack();
      logic [31:0] v;
      resp_hold = 1'b1;
      put_cb(32'h100, F_WACK | F_SINC | F_DINC, 32'h200, 32'h2C0, 32'd8, 32'h0);
      start(32'h100);
      repeat (20) @(negedge clk);
      rr(4'd5, v); chk("R9 wait for ack count", v, 32'd4);
      rr(4'd0, v); chk("R9 wait for ack status", v, 32'h41);
      resp_hold = 1'b0;
      wait_idle();
      chk("R9 acked word1", mem[8'hB1], 32'hC0DE_0001);
      rr(4'd0, v); chk("R9 end after acks", v, 32'h3);
      clear_cs();
   endtask

   task automatic t_abort();
      logic [31:0] v;
      for (int i = 0; i < 4; i++) poke(32'h2E0 + 4*i, 32'h1111_1111);
      put_cb(32'h100, F_IRQ | F_SPAC | F_SINC | F_DINC, 32'h200, 32'h2E0, 32'd8, 32'h120);
      put_cb(32'h120, F_SINC | F_DINC, 32'h208, 32'h2E8, 32'd8, 32'h0);
      dreq = 1'b0;
      start(32'h100);
      repeat (20) @(negedge clk);
      rw(4'd0, 32'h4000_0001);
      wait_idle();
      chk("R10 skipped word0", mem[8'hB8], 32'h1111_1111);
      chk("R10 skipped word1", mem[8'hB9], 32'h1111_1111);
      chk("R10 next word0", mem[8'hBA], 32'hC0DE_0002);
      chk("R10 next word1", mem[8'hBB], 32'hC0DE_0003);
      rr(4'd0, v); chk("R10 status", v, 32'h3);
      chk("R10 no irq", {31'd0, irq}, 32'h0);
      clear_cs();
   endtask

   task automatic t_softreset();
      logic [31:0] v;
      put_cb(32'h100, F_SPAC | F_SINC | F_DINC, 32'h200, 32'h2F0, 32'd8, 32'h0);
      dreq = 1'b0;
      start(32'h100);
      repeat (20) @(negedge clk);
      rw(4'd0, 32'h8000_0000);
      rr(4'd0, v); chk("R11 status", v, 32'h10);
      rr(4'd1, v); chk("R11 cb address", v, 32'h0);
      rr(4'd5, v); chk("R11 count", v, 32'h0);
      rr(4'd3, v); chk("R11 source", v, 32'h0);
   endtask

   task automatic t_align();
      logic [31:0] v;
      rw(4'd1, 32'h13F);
      rr(4'd1, v); chk("R12 aligned address", v, 32'h120);
      rw(4'd1, 32'h0);
   endtask

   task automatic t_length();
      logic [31:0] v;
      for (int i = 0; i < 3; i++) poke(32'h260 + 4*i, 32'h0);
      put_cb(32'h100, F_SINC | F_DINC, 32'h200, 32'h260, 32'd10, 32'h0);
      start(32'h100); wait_idle();
      chk("R14 odd count word1", mem[8'h99], 32'hC0DE_0001);
      chk("R14 odd count tail", mem[8'h9A], 32'h0);
      clear_cs();
      put_cb(32'h100, F_SINC | F_DINC, 32'h200, 32'h260, 32'd0, 32'h0);
      poke(32'h260, 32'h7777_7777);
      start(32'h100); wait_idle();
      chk("R14 zero count no write", mem[8'h98], 32'h7777_7777);
      rr(4'd0, v); chk("R14 zero count ends", v, 32'h3);
      rr(4'd3, v); chk("R14 zero count source", v, 32'h200);
      clear_cs();
   endtask

   task automatic t_lite();
      logic [31:0] v;
      put_cb(32'h140, F_SPAC | F_SZER | F_DDRP, 32'h0, 32'h0, 32'h0002_0000, 32'h0);
      lw(4'd1, 32'h140);
      lw(4'd0, 32'h1);
      repeat (20) @(negedge clk);
      lr(4'd5, v); chk("R13 capped count", v, 32'd65532);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      for (int i = 0; i < 8; i++) poke(32'h200 + 4*i, 32'hC0DE_0000 + i);
      t_copy();
      t_w1c();
      t_chain();
      t_sources();
      t_pace();
      t_pause();
      t_waitack();
      t_abort();
      t_softreset();
      t_align();
      t_length();
      t_lite();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      end
   end

endmodule